// File: doc/BRIEF.md
# Unit-Scaled Watchdog Timer

This block is a watchdog that counts in coarse units. Software programs it through three byte registers, each with its own write strobe and a shared write-data byte: a count register, a control register and a status register. Writing a nonzero count arms the timer, and writing it again restarts the countdown; this rewrite is the only keepalive. Writing zero turns the timer off. The count is measured in units of `UNIT_CYCLES` clocks. The first unit after every load lasts half a unit, so a count of N expires `UNIT_CYCLES*N - UNIT_CYCLES/2` clocks after the write.

On expiry the block does three things:
- it latches a sticky timed-out flag;
- it emits a reset pulse `RST_CYCLES` clocks long;
- if enabled in the control register, it blinks an LED output that toggles every `BLINK_CYCLES` clocks.

The reset and LED pins are driven only while the `dev_active` input is high.

The sequencer has four states:
- `WD_IDLE`: disarmed.
- `WD_HALF`: the half-length first unit is running.
- `WD_FULL`: full units are running.
- `WD_FIRED`: the timer has expired.

Its transitions are:
- *arm*: a nonzero count write, from any state, goes to `WD_HALF`.
- *disarm*: a zero count write, from any state, goes to `WD_IDLE`.
- *first-tick*: `WD_HALF` goes to `WD_FULL` when more than one unit remains.
- *expire*: the last unit tick, from `WD_HALF` or `WD_FULL`, goes to `WD_FIRED`.

Top module: `wdt_unit_timer`

## Requirements
- R1: After reset, `cnt_q`, `ctl_q` and `sts_q` read 0x00, and `wdt_rst_o` and `led_o` are low.
- R2: A write of N (1..255) to the count register expires exactly `UNIT_CYCLES*N - UNIT_CYCLES/2` clock edges after the edge that takes the write. The first unit is half length, and the flag is still clear one edge earlier.
- R3: Rewriting a nonzero count while armed restarts the countdown, so expiry is measured from the latest write.
- R4: Writing 0x00 to the count register disarms the timer, and no expiry follows. The stop sequence leaves all three registers at 0x00 with no timeout pending. That sequence is 0xFF then 0x00 to count, then 0x00 to control and 0x00 to status.
- R5: On expiry, `sts_q` bit 0 becomes 1 on the expiry edge. `wdt_rst_o` is high for exactly `RST_CYCLES` cycles starting at that edge.
- R6: The timed-out flag stays set through count reloads and through status writes with bit 0 = 1. A status write with bit 0 = 0 (e.g. 0x00) clears it. Bits 7..1 of `sts_q` read 0.
- R7: Control bit 3 is the LED enable and is the only stored control bit; other bits read 0. While the flag and the enable are both 1, `led_o` starts low and toggles every `BLINK_CYCLES` edges. Otherwise `led_o` is low one edge later.
- R8: With `dev_active` low, `wdt_rst_o` and `led_o` stay low, while the flag is still set on expiry.
- R9: The count range limits hold. N=1 expires after `UNIT_CYCLES/2` edges, and N=255 after `255*UNIT_CYCLES - UNIT_CYCLES/2` edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cnt_we | input | 1 | Write strobe for the count register |
| ctl_we | input | 1 | Write strobe for the control register |
| sts_we | input | 1 | Write strobe for the status register |
| wdata | input | 8 | Write data shared by all three registers |
| dev_active | input | 1 | Enables driving of the reset and LED pins |
| cnt_q | output | 8 | Count register readback |
| ctl_q | output | 8 | Control register readback (bit 3 LED enable) |
| sts_q | output | 8 | Status readback (bit 0 timed-out flag) |
| wdt_rst_o | output | 1 | Watchdog reset pulse |
| led_o | output | 1 | Blinking timeout LED |

## Verification
The bench measures expiry to the exact edge for counts of 1, 3 and 255. A design that gave the first unit full length, or counted one unit too few, is caught one edge early or late. A keepalive issued partway through a countdown must push the expiry out by a full period from the rewrite, which a design that ignores the rewrite or only reloads the unit count fails. The bench also checks that the flag survives reloads and set-attempts but not a zero write, that a disarmed timer never fires, that the LED toggles on its exact edges, and that a low `dev_active` silences both pins while the flag still latches.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
    typedef enum logic [1:0] {
        WD_IDLE  = 2'd0,
        WD_HALF  = 2'd1,
        WD_FULL  = 2'd2,
        WD_FIRED = 2'd3
    } wd_state_e;

    localparam int LED_EN_BIT = 3;
    localparam int FLAG_BIT   = 0;
endpackage

// File: rtl/wdt_unit_prescaler.sv
module wdt_unit_prescaler #(
    parameter int UNIT_CYCLES = 20
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    input  logic run,
    output logic unit_tick
);
    localparam int PW   = (UNIT_CYCLES > 2) ? $clog2(UNIT_CYCLES) : 1;
    localparam int HALF = UNIT_CYCLES / 2;

    logic [PW-1:0] pre_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pre_cnt <= '0;
        end else if (restart) begin
            pre_cnt <= PW'(HALF - 1);
        end else if (run) begin
            if (pre_cnt == '0) pre_cnt <= PW'(UNIT_CYCLES - 1);
            else               pre_cnt <= pre_cnt - 1'b1;
        end
    end

    assign unit_tick = run && !restart && (pre_cnt == '0);

    p_tick_needs_run_r2: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> !unit_tick);
endmodule

// File: rtl/wdt_count_fsm.sv
module wdt_count_fsm
    import wdt_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cnt_we,
    input  logic             sts_we,
    input  logic [CNT_W-1:0] wdata,
    input  logic             unit_tick,
    output logic [CNT_W-1:0] cnt_q,
    output logic             run,
    output logic             fire,
    output logic             flag
);
    wd_state_e        state, state_nxt;
    logic [CNT_W-1:0] units_left;
    logic [CNT_W-1:0] cnt_reg;
    logic             last_unit;

    assign last_unit = (units_left == CNT_W'(1));

    // next-state logic
    always_comb begin
        state_nxt = state;
        if (cnt_we) begin
            state_nxt = (wdata != '0) ? WD_HALF : WD_IDLE;
        end else begin
            unique case (state)
                WD_IDLE:  state_nxt = WD_IDLE;
                WD_HALF:  if (unit_tick) state_nxt = last_unit ? WD_FIRED : WD_FULL;
                WD_FULL:  if (unit_tick && last_unit) state_nxt = WD_FIRED;
                WD_FIRED: state_nxt = WD_FIRED;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= WD_IDLE;
        else        state <= state_nxt;
    end

    // outputs of the sequencer
    always_comb begin
        run  = 1'b0;
        fire = 1'b0;
        unique case (state)
            WD_IDLE:  run = 1'b0;
            WD_HALF, WD_FULL: begin
                run  = 1'b1;
                fire = !cnt_we && unit_tick && last_unit;
            end
            WD_FIRED: run = 1'b0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            units_left <= '0;
            cnt_reg    <= '0;
        end else if (cnt_we) begin
            units_left <= wdata;
            cnt_reg    <= wdata;
        end else if (run && unit_tick) begin
            units_left <= units_left - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                            flag <= 1'b0;
        else if (fire)                         flag <= 1'b1;
        else if (sts_we && !wdata[FLAG_BIT])   flag <= 1'b0;
    end

    assign cnt_q = cnt_reg;

    p_idle_after_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_we && wdata == '0) |=> (state == WD_IDLE));
    p_reload_restarts_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_we && wdata != '0) |=> (state == WD_HALF && units_left == $past(wdata)));
    p_fire_sets_flag_r5: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> (flag && state == WD_FIRED));
    p_flag_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !sts_we) |=> flag);
endmodule

// File: rtl/wdt_blink.sv
module wdt_blink #(
    parameter int BLINK_CYCLES = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic led
);
    localparam int BW = (BLINK_CYCLES > 2) ? $clog2(BLINK_CYCLES) : 1;

    logic [BW-1:0] div;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div <= '0;
            led <= 1'b0;
        end else if (!en) begin
            div <= '0;
            led <= 1'b0;
        end else if (div == BW'(BLINK_CYCLES - 1)) begin
            div <= '0;
            led <= ~led;
        end else begin
            div <= div + 1'b1;
        end
    end

    p_led_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !led);
endmodule

// File: rtl/wdt_unit_timer.sv
module wdt_unit_timer
    import wdt_pkg::*;
#(
    parameter int UNIT_CYCLES  = 20,
    parameter int RST_CYCLES   = 3,
    parameter int BLINK_CYCLES = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cnt_we,
    input  logic       ctl_we,
    input  logic       sts_we,
    input  logic [7:0] wdata,
    input  logic       dev_active,
    output logic [7:0] cnt_q,
    output logic [7:0] ctl_q,
    output logic [7:0] sts_q,
    output logic       wdt_rst_o,
    output logic       led_o
);
    localparam int RW = $clog2(RST_CYCLES + 1);

    logic          run, fire, flag, unit_tick, led_en, led_raw;
    logic [RW-1:0] rst_left;

    wdt_unit_prescaler #(.UNIT_CYCLES(UNIT_CYCLES)) u_pre (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart   (cnt_we && (wdata != 8'h00)),
        .run       (run),
        .unit_tick (unit_tick)
    );

    wdt_count_fsm #(.CNT_W(8)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .cnt_we    (cnt_we),
        .sts_we    (sts_we),
        .wdata     (wdata),
        .unit_tick (unit_tick),
        .cnt_q     (cnt_q),
        .run       (run),
        .fire      (fire),
        .flag      (flag)
    );

    wdt_blink #(.BLINK_CYCLES(BLINK_CYCLES)) u_blink (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (flag && led_en),
        .led   (led_raw)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      led_en <= 1'b0;
        else if (ctl_we) led_en <= wdata[LED_EN_BIT];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              rst_left <= '0;
        else if (fire)           rst_left <= RW'(RST_CYCLES);
        else if (rst_left != '0) rst_left <= rst_left - 1'b1;
    end

    always_comb begin
        ctl_q             = 8'h00;
        ctl_q[LED_EN_BIT] = led_en;
        sts_q             = 8'h00;
        sts_q[FLAG_BIT]   = flag;
    end

    assign wdt_rst_o = dev_active && (rst_left != '0);
    assign led_o     = dev_active && led_raw;

    p_pulse_on_fire_r5: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> (rst_left != '0 && flag));
endmodule

// File: tb/tb_wdt_unit_timer.sv
module tb_wdt_unit_timer;
    localparam int UNIT  = 20;
    localparam int RSTC  = 3;
    localparam int BLINK = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cnt_we = 1'b0, ctl_we = 1'b0, sts_we = 1'b0;
    logic [7:0] wdata = 8'h00;
    logic       dev_active = 1'b1;
    logic [7:0] cnt_q, ctl_q, sts_q;
    logic       wdt_rst_o, led_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    wdt_unit_timer #(.UNIT_CYCLES(UNIT), .RST_CYCLES(RSTC), .BLINK_CYCLES(BLINK)) dut (
        .clk(clk), .rst_n(rst_n), .cnt_we(cnt_we), .ctl_we(ctl_we), .sts_we(sts_we),
        .wdata(wdata), .dev_active(dev_active), .cnt_q(cnt_q), .ctl_q(ctl_q),
        .sts_q(sts_q), .wdt_rst_o(wdt_rst_o), .led_o(led_o)
    );

    task automatic check(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // sel: 0 count, 1 control, 2 status
    task automatic wr(int sel, logic [7:0] d);
        @(negedge clk);
        wdata  = d;
        cnt_we = (sel == 0);
        ctl_we = (sel == 1);
        sts_we = (sel == 2);
        @(negedge clk);
        cnt_we = 1'b0; ctl_we = 1'b0; sts_we = 1'b0;
    endtask

    task automatic cleanup();
        wr(0, 8'h00);
        wr(1, 8'h00);
        wr(2, 8'h00);
        repeat (RSTC + 2) @(negedge clk);
    endtask

    function automatic int period(int n);
        return UNIT * n - UNIT / 2;
    endfunction

    task automatic t_reset();
        check("R1 cnt_q", cnt_q, 0);
        check("R1 ctl_q", ctl_q, 0);
        check("R1 sts_q", sts_q, 0);
        check("R1 rst", wdt_rst_o, 0);
        check("R1 led", led_o, 0);
    endtask

    task automatic t_expiry(int n, string tag);
        wr(0, 8'(n));
        check({tag, " cnt_q"}, cnt_q, n);
        repeat (period(n) - 1) @(negedge clk);
        check({tag, " flag before"}, sts_q, 0);
        check({tag, " rst before"}, wdt_rst_o, 0);
        @(negedge clk);
        check({tag, " flag at expiry"}, sts_q, 1);
        for (int i = 0; i < RSTC; i++) begin
            check("R5 rst high", wdt_rst_o, 1);
            @(negedge clk);
        end
        check("R5 rst low after pulse", wdt_rst_o, 0);
        cleanup();
    endtask

    task automatic t_keepalive();
        wr(0, 8'd2);
        repeat (20) @(negedge clk);
        wr(0, 8'd2);
        repeat (period(2) - 1) @(negedge clk);
        check("R3 no expiry before reloaded period", sts_q, 0);
        @(negedge clk);
        check("R3 expiry from latest write", sts_q, 1);
        cleanup();
    endtask

    task automatic t_disable();
        int seen;
        seen = 0;
        wr(0, 8'd3);
        repeat (10) @(negedge clk);
        wr(0, 8'h00);
        for (int i = 0; i < 200; i++) begin
            @(negedge clk);
            if (wdt_rst_o || sts_q != 0) seen++;
        end
        check("R4 disarmed never fires", seen, 0);
        wr(1, 8'h08);
        wr(0, 8'hFF);
        wr(0, 8'h00);
        wr(1, 8'h00);
        wr(2, 8'h00);
        check("R4 stop cnt_q", cnt_q, 0);
        check("R4 stop ctl_q", ctl_q, 0);
        seen = 0;
        for (int i = 0; i < 300; i++) begin
            @(negedge clk);
            if (wdt_rst_o || sts_q != 0) seen++;
        end
        check("R4 stop sequence leaves nothing pending", seen, 0);
    endtask

    task automatic t_sticky();
        wr(0, 8'd1);
        repeat (period(1)) @(negedge clk);
        check("R6 flag set", sts_q, 1);
        wr(0, 8'd5);
        check("R6 flag survives reload", sts_q, 1);
        wr(2, 8'h01);
        check("R6 flag survives bit0=1 write", sts_q, 1);
        wr(2, 8'h00);
        check("R6 flag cleared by 0x00", sts_q, 0);
        cleanup();
    endtask

    task automatic t_led();
        int hi;
        wr(1, 8'hF7);
        check("R7 ctl other bits not stored", ctl_q, 0);
        wr(1, 8'h08);
        check("R7 ctl bit3 stored", ctl_q, 8);
        wr(0, 8'd1);
        repeat (period(1)) @(negedge clk);
        check("R7 led low at expiry", led_o, 0);
        repeat (BLINK - 1) @(negedge clk);
        check("R7 led low before first toggle", led_o, 0);
        @(negedge clk);
        check("R7 led first toggle", led_o, 1);
        repeat (BLINK) @(negedge clk);
        check("R7 led second toggle", led_o, 0);
        repeat (BLINK) @(negedge clk);
        check("R7 led third toggle", led_o, 1);
        wr(2, 8'h00);
        @(negedge clk);
        check("R7 led off after flag clear", led_o, 0);
        cleanup();
        wr(0, 8'd1);
        hi = 0;
        for (int i = 0; i < period(1) + 4 * BLINK; i++) begin
            @(negedge clk);
            if (led_o) hi++;
        end
        check("R7 led stays low when disabled", hi, 0);
        cleanup();
    endtask

    task automatic t_gate();
        int hi;
        dev_active = 1'b0;
        wr(1, 8'h08);
        wr(0, 8'd1);
        hi = 0;
        for (int i = 0; i < period(1) + 4 * BLINK; i++) begin
            @(negedge clk);
            if (wdt_rst_o || led_o) hi++;
        end
        check("R8 pins silent while inactive", hi, 0);
        check("R8 flag still set", sts_q, 1);
        dev_active = 1'b1;
        cleanup();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_expiry(3, "R2");
        t_expiry(1, "R9 min");
        t_expiry(255, "R9 max");
        t_keepalive();
        t_disable();
        t_sticky();
        t_led();
        t_gate();
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual 0 expected 1 (run completed)");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule